// File: doc/BRIEF.md
# Dual-Compare Byte-Bus Timer

A timer/counter for a byte-wide register bus. It advances once for each cycle in which `tick_i` is high. A mode bit selects how wide it counts. With the bit clear, only the low counter byte counts and the high byte is an ordinary register. With the bit set, the two bytes are chained into one 16-bit counter.

There are two compare channels, A and B. Each has a sticky match flag that software clears by writing a one to it. A second mode bit turns on clear-on-compare: a compare-A match then reloads the counter with zero instead of advancing it. Writing the counter low byte suppresses compare detection on the next tick, so a freshly loaded value equal to a compare value raises no flag. In 16-bit mode a single staging byte serves every byte pair, which makes 16-bit transfers atomic. The counter and the compare pair are both written high byte first and low byte second. The counter is read low byte first and high byte second.

Register map (3-bit address): 0 = mode, 1 = counter low, 2 = counter high, 3 = compare A, 4 = compare B, 5 = flags. Unused addresses read zero.

Top module: `dual_cmp_timer`

## Requirements
- R1: After reset the counter bytes, both compare registers, the mode register and both flags read zero, and both flag outputs are low.
- R2: With mode bit 0 (wide) clear, each tick increments the low counter byte, with 0xFF wrapping to 0x00. The high byte keeps its value and is read and written directly at address 2.
- R3: With wide set, each tick increments the 16-bit value {high, low}, and a carry from the low byte advances the high byte.
- R4: A write to address 1 blocks compare detection on the next tick: neither flag sets, and no clear-on-compare reload takes place on that tick.
- R5: With wide set, a write to address 2 or 4 loads only the staging byte. A write to address 1 loads the low counter byte with the bus data and the high byte with the staging byte in the same cycle. A write to address 3 loads compare A with the bus data and compare B with the staging byte in the same cycle.
- R6: With wide set, a read of address 1 copies the current high counter byte into the staging byte, and a read of address 2 returns the staging byte.
- R7: Compare A is tested on every tick. In narrow mode it is compared with the low byte. In wide mode {compare B, compare A} is compared with {high, low}. A match sets flag bit 0 (`irq_a_o`).
- R8: Compare B is tested on every tick. In narrow mode it is compared with the low byte. In wide mode it is compared with the high byte. A match sets flag bit 1 (`irq_b_o`).
- R9: With mode bit 1 (clear-on-compare) set, a tick that detects a compare-A match loads the counter with zero. In narrow mode only the low byte is cleared.
- R10: Writing address 5 clears each flag whose data bit is one and leaves each flag whose data bit is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Count enable, one count per high cycle |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe (side effects only) |
| addr_i | input | 3 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i (combinational) |
| irq_a_o | output | 1 | Compare A match flag |
| irq_b_o | output | 1 | Compare B match flag |

## Verification
The hardest situation to bring about is a compare match that is due on exactly the tick after a low-byte write. The stimulus lands the counter on the compare value through the bus and then ticks once. It repeats this with clear-on-compare on, to show that neither a flag nor a reload appears. Atomic reads are checked by reading the low byte while the counter sits at 0xFF in the low byte, letting it carry, and then reading the high byte. A pending staging write is shown to leave the counter and compare B unchanged by reading them back before the committing low-byte write.

// File: rtl/timer_pkg.sv
package timer_pkg;
  localparam logic [2:0] ADR_MODE  = 3'd0;
  localparam logic [2:0] ADR_CNTL  = 3'd1;
  localparam logic [2:0] ADR_CNTH  = 3'd2;
  localparam logic [2:0] ADR_CMPA  = 3'd3;
  localparam logic [2:0] ADR_CMPB  = 3'd4;
  localparam logic [2:0] ADR_FLAGS = 3'd5;

  typedef struct packed {
    logic clr_on_cmp;
    logic wide;
  } mode_t;
endpackage

// File: rtl/tmr_regif.sv
module tmr_regif
  import timer_pkg::*;
#(
  parameter int BW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic          rd_en_i,
  input  logic [2:0]    addr_i,
  input  logic [BW-1:0] wdata_i,
  output logic [BW-1:0] rdata_o,
  input  logic [BW-1:0] cnt_lo_i,
  input  logic [BW-1:0] cnt_hi_i,
  input  logic [1:0]    flags_i,
  output mode_t         mode_o,
  output logic [BW-1:0] cmp_a_o,
  output logic [BW-1:0] cmp_b_o,
  output logic          ld_lo_o,
  output logic          ld_hi_o,
  output logic [BW-1:0] lo_val_o,
  output logic [BW-1:0] hi_val_o,
  output logic          w1c_en_o,
  output logic [1:0]    w1c_mask_o
);
  mode_t         mode_q;
  logic [BW-1:0] cmp_a_q, cmp_b_q, stage_q;
  logic          wr_mode, wr_lo, wr_hi, wr_a, wr_b, rd_lo;

  assign wr_mode = wr_en_i && addr_i == ADR_MODE;
  assign wr_lo   = wr_en_i && addr_i == ADR_CNTL;
  assign wr_hi   = wr_en_i && addr_i == ADR_CNTH;
  assign wr_a    = wr_en_i && addr_i == ADR_CMPA;
  assign wr_b    = wr_en_i && addr_i == ADR_CMPB;
  assign rd_lo   = rd_en_i && addr_i == ADR_CNTL;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q  <= '0;
      cmp_a_q <= '0;
      cmp_b_q <= '0;
      stage_q <= '0;
    end else begin
      if (wr_mode) mode_q <= mode_t'(wdata_i[1:0]);
      if (wr_a) begin
        cmp_a_q <= wdata_i;
        if (mode_q.wide) cmp_b_q <= stage_q;
      end
      if (wr_b && !mode_q.wide) cmp_b_q <= wdata_i;
      // staging byte: high-byte writes take priority over read latching
      if ((wr_hi || wr_b) && mode_q.wide) stage_q <= wdata_i;
      else if (rd_lo && mode_q.wide)      stage_q <= cnt_hi_i;
    end
  end

  assign ld_lo_o    = wr_lo;
  assign lo_val_o   = wdata_i;
  assign ld_hi_o    = mode_q.wide ? wr_lo : wr_hi;
  assign hi_val_o   = mode_q.wide ? stage_q : wdata_i;
  assign w1c_en_o   = wr_en_i && addr_i == ADR_FLAGS;
  assign w1c_mask_o = wdata_i[1:0];
  assign mode_o     = mode_q;
  assign cmp_a_o    = cmp_a_q;
  assign cmp_b_o    = cmp_b_q;

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      ADR_MODE:  rdata_o[1:0] = mode_q;
      ADR_CNTL:  rdata_o = cnt_lo_i;
      ADR_CNTH:  rdata_o = mode_q.wide ? stage_q : cnt_hi_i;
      ADR_CMPA:  rdata_o = cmp_a_q;
      ADR_CMPB:  rdata_o = cmp_b_q;
      ADR_FLAGS: rdata_o[1:0] = flags_i;
      default:   rdata_o = '0;
    endcase
  end

  // R5: wide-mode high-byte write lands in staging only
  a_r5_stage_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_hi && mode_q.wide) |=> stage_q == $past(wdata_i));
  // R6: low-byte read snapshots the high counter byte
  a_r6_read_latch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_lo && mode_q.wide && !wr_en_i) |=> stage_q == $past(cnt_hi_i));
  // R5: staged compare-B write leaves compare B untouched
  a_r5_cmpb_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_b && mode_q.wide) |=> cmp_b_q == $past(cmp_b_q));
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int BW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          wide_i,
  input  logic          clr_i,
  input  logic          ld_lo_i,
  input  logic          ld_hi_i,
  input  logic [BW-1:0] lo_val_i,
  input  logic [BW-1:0] hi_val_i,
  output logic [BW-1:0] cnt_lo_o,
  output logic [BW-1:0] cnt_hi_o,
  output logic          blk_o
);
  localparam logic [BW-1:0] ONES = '1;
  logic [BW-1:0] lo_q, hi_q;
  logic          blk_q, carry;

  assign carry = lo_q == ONES;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q  <= '0;
      hi_q  <= '0;
      blk_q <= 1'b0;
    end else begin
      if (ld_lo_i)     lo_q <= lo_val_i;
      else if (tick_i) lo_q <= clr_i ? '0 : lo_q + 1'b1;

      if (ld_hi_i)               hi_q <= hi_val_i;
      else if (tick_i && wide_i) hi_q <= clr_i ? '0 : hi_q + BW'(carry);

      if (ld_lo_i)     blk_q <= 1'b1;
      else if (tick_i) blk_q <= 1'b0;
    end
  end

  assign cnt_lo_o = lo_q;
  assign cnt_hi_o = hi_q;
  assign blk_o    = blk_q;

  // R2: narrow counting advances low byte, holds high byte
  a_r2_narrow_inc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !wide_i && !clr_i && !ld_lo_i && !ld_hi_i)
      |=> (lo_q == $past(lo_q) + 1'b1) && (hi_q == $past(hi_q)));
  // R9: clear-on-compare reload
  a_r9_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && clr_i && !ld_lo_i && !ld_hi_i) |=> lo_q == '0);
endmodule

// File: rtl/tmr_match.sv
module tmr_match #(
  parameter int BW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          blk_i,
  input  logic          wide_i,
  input  logic          ctc_i,
  input  logic [BW-1:0] cnt_lo_i,
  input  logic [BW-1:0] cnt_hi_i,
  input  logic [BW-1:0] cmp_a_i,
  input  logic [BW-1:0] cmp_b_i,
  input  logic          w1c_en_i,
  input  logic [1:0]    w1c_mask_i,
  output logic          clr_o,
  output logic [1:0]    flags_o
);
  logic       eq_a, eq_b;
  logic [1:0] hit, clr_mask, flags_q;

  assign eq_a = wide_i ? ({cnt_hi_i, cnt_lo_i} == {cmp_b_i, cmp_a_i})
                       : (cnt_lo_i == cmp_a_i);
  assign eq_b = wide_i ? (cnt_hi_i == cmp_b_i) : (cnt_lo_i == cmp_b_i);

  assign hit      = {2{tick_i && !blk_i}} & {eq_b, eq_a};
  assign clr_mask = w1c_en_i ? w1c_mask_i : 2'b00;
  assign clr_o    = hit[0] && ctc_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flags_q <= '0;
    else         flags_q <= (flags_q & ~clr_mask) | hit;
  end

  assign flags_o = flags_q;

  // R4: blocked tick raises no new flag
  a_r4_blocked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && blk_i) |=> (flags_q & ~$past(flags_q)) == 2'b00);
  // R10: written ones clear flags when no tick competes
  a_r10_w1c: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (w1c_en_i && !tick_i) |=> (flags_q & $past(w1c_mask_i)) == 2'b00);
  // R7/R8: flags only rise on a tick
  a_r7_tick_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> (flags_q & ~$past(flags_q)) == 2'b00);
endmodule

// File: rtl/dual_cmp_timer.sv
module dual_cmp_timer
  import timer_pkg::*;
#(
  parameter int BW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          wr_en_i,
  input  logic          rd_en_i,
  input  logic [2:0]    addr_i,
  input  logic [BW-1:0] wdata_i,
  output logic [BW-1:0] rdata_o,
  output logic          irq_a_o,
  output logic          irq_b_o
);
  mode_t         mode;
  logic [BW-1:0] cmp_a, cmp_b, cnt_lo, cnt_hi, lo_val, hi_val;
  logic          ld_lo, ld_hi, w1c_en, blk, clr;
  logic [1:0]    w1c_mask, flags;

  tmr_regif #(.BW(BW)) u_regif (
    .clk_i, .rst_ni, .wr_en_i, .rd_en_i, .addr_i, .wdata_i, .rdata_o,
    .cnt_lo_i(cnt_lo), .cnt_hi_i(cnt_hi), .flags_i(flags),
    .mode_o(mode), .cmp_a_o(cmp_a), .cmp_b_o(cmp_b),
    .ld_lo_o(ld_lo), .ld_hi_o(ld_hi), .lo_val_o(lo_val), .hi_val_o(hi_val),
    .w1c_en_o(w1c_en), .w1c_mask_o(w1c_mask)
  );

  tmr_counter #(.BW(BW)) u_counter (
    .clk_i, .rst_ni, .tick_i, .wide_i(mode.wide), .clr_i(clr),
    .ld_lo_i(ld_lo), .ld_hi_i(ld_hi), .lo_val_i(lo_val), .hi_val_i(hi_val),
    .cnt_lo_o(cnt_lo), .cnt_hi_o(cnt_hi), .blk_o(blk)
  );

  tmr_match #(.BW(BW)) u_match (
    .clk_i, .rst_ni, .tick_i, .blk_i(blk), .wide_i(mode.wide),
    .ctc_i(mode.clr_on_cmp), .cnt_lo_i(cnt_lo), .cnt_hi_i(cnt_hi),
    .cmp_a_i(cmp_a), .cmp_b_i(cmp_b), .w1c_en_i(w1c_en),
    .w1c_mask_i(w1c_mask), .clr_o(clr), .flags_o(flags)
  );

  assign irq_a_o = flags[0];
  assign irq_b_o = flags[1];
endmodule

// File: tb/dual_cmp_timer_test.sv
module dual_cmp_timer_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0, rdata;
  logic       irq_a, irq_b;
  int         n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  dual_cmp_timer uut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .wr_en_i(wr_en),
    .rd_en_i(rd_en), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .irq_a_o(irq_a), .irq_b_o(irq_b)
  );

  task automatic chk(input string req, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  // all tasks start and end at a falling edge
  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    addr = a; rd_en = 1'b1;
    #1 d = rdata;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic ticks(input int n);
    tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), d);
      chk("R1 reset register", d, 0);
    end
    chk("R1 irq_a reset", irq_a, 0);
    chk("R1 irq_b reset", irq_b, 0);
  endtask

  task automatic t_narrow_match();
    logic [7:0] d;
    wr(3, 8'd5); wr(4, 8'd3);
    ticks(3);
    chk("R7 no early flags", {irq_b, irq_a}, 0);
    ticks(1);
    chk("R8 B match narrow", irq_b, 1);
    chk("R7 A idle", irq_a, 0);
    rd(1, d); chk("R2 low count", d, 4);
    ticks(2);
    chk("R7 A match narrow", irq_a, 1);
    rd(5, d); chk("R10 flag read", d, 3);
    wr(5, 8'h03);
    chk("R10 flags cleared", {irq_b, irq_a}, 0);
  endtask

  task automatic t_ctc_narrow();
    logic [7:0] d;
    wr(0, 8'h02); wr(1, 8'h00);
    ticks(5);
    rd(1, d); chk("R9 before match", d, 5);
    chk("R9 no A yet", irq_a, 0);
    ticks(1);
    rd(1, d); chk("R9 cleared on match", d, 0);
    chk("R9 A flagged", irq_a, 1);
    wr(5, 8'h03);
  endtask

  task automatic t_block();
    logic [7:0] d;
    wr(0, 8'h00); wr(3, 8'd7); wr(4, 8'h80);
    wr(1, 8'd7); ticks(1);
    chk("R4 blocked A", irq_a, 0);
    rd(1, d); chk("R4 counted on", d, 8);
    wr(1, 8'd6); ticks(2);
    chk("R4 match after block", irq_a, 1);
    wr(5, 8'h01);
    wr(0, 8'h02); wr(1, 8'd7); ticks(1);
    rd(1, d); chk("R4 no reload when blocked", d, 8);
    chk("R4 blocked A ctc", irq_a, 0);
    wr(5, 8'h03);
  endtask

  task automatic t_wrap();
    logic [7:0] d;
    wr(0, 8'h00); wr(2, 8'h77); wr(1, 8'hFE);
    ticks(2);
    rd(1, d); chk("R2 wrap low", d, 0);
    rd(2, d); chk("R2 high held", d, 8'h77);
  endtask

  task automatic t_wide_rw();
    logic [7:0] d;
    wr(0, 8'h01); wr(2, 8'h12); wr(1, 8'hFF);
    rd(1, d); chk("R5 low committed", d, 8'hFF);
    ticks(1);
    rd(2, d); chk("R6 latched high", d, 8'h12);
    rd(1, d); chk("R3 carry low", d, 8'h00);
    rd(2, d); chk("R3 carry high", d, 8'h13);
    wr(2, 8'h55);
    rd(1, d); chk("R5 low untouched", d, 8'h00);
    rd(2, d); chk("R5 high untouched", d, 8'h13);
  endtask

  task automatic t_wide_cmp();
    logic [7:0] d;
    wr(0, 8'h03); wr(4, 8'h01);
    rd(4, d); chk("R5 cmp B staged only", d, 8'h80);
    wr(3, 8'h02);
    rd(4, d); chk("R5 cmp B committed", d, 8'h01);
    rd(3, d); chk("R5 cmp A committed", d, 8'h02);
    wr(2, 8'h00); wr(1, 8'hFE); wr(5, 8'h03);
    ticks(2);
    chk("R8 no B below", {irq_b, irq_a}, 0);
    ticks(1);
    chk("R8 B on high byte", irq_b, 1);
    chk("R7 A not yet wide", irq_a, 0);
    ticks(2);
    chk("R7 A wide match", irq_a, 1);
    rd(1, d); chk("R9 wide clear low", d, 0);
    rd(2, d); chk("R9 wide clear high", d, 0);
  endtask

  task automatic t_w1c();
    logic [7:0] d;
    wr(5, 8'h01);
    chk("R10 A cleared", irq_a, 0);
    chk("R10 B kept", irq_b, 1);
    rd(5, d); chk("R10 flag reg", d, 2);
    wr(5, 8'h02);
    chk("R10 B cleared", irq_b, 0);
  endtask

  initial begin
    #100000;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_narrow_match();
    t_ctc_narrow();
    t_block();
    t_wrap();
    t_wide_rw();
    t_wide_cmp();
    t_w1c();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule